// File: doc/BRIEF.md
# Test-and-Set Lock Memory

A small on-chip word memory that several requesters share for mutual exclusion. Each requester has its own request port and its own response port. The request port uses a valid/ready handshake and carries an opcode, a word address and write data. The block grants one request per cycle. The operations are a plain load, a plain store and an atomic test-and-set. A test-and-set hands back the word's previous contents and leaves the set constant in the word. The read and the write happen as one indivisible step with respect to every other requester.

Software acquires a lock by issuing test-and-set until the response reports success. Success means the old value was the clear constant. Software releases the lock by storing the clear constant. Both constants are parameters, so a system can use encodings other than 1 and 0.

After reset, the block spends one cycle on each word writing the clear constant, so every lock starts free. It accepts no requests during that time.

Top module: `tas_lock_mem`

## Requirements
- R1: After reset is released, `req_ready` stays 0 for exactly 2^ADDR_W cycles while every word is written with CLR_VAL. The first request is accepted in the following cycle, and a load of any word then returns CLR_VAL.
- R2: At most one bit of `req_ready` is 1 in any cycle, and only for a requester whose `req_valid` is 1. A request is accepted in a cycle where both are 1.
- R3: Arbitration is round-robin. A requester that holds `req_valid` is accepted after at most N_REQ-1 acceptances of other requesters.
- R4: The response for an accepted request appears on that requester's response lane only. `rsp_valid` is high for one cycle, two clock edges after the accepting edge.
- R5: Opcode 2'b00 (load) returns the word's current contents and leaves the word unchanged.
- R6: Opcode 2'b01 (store) writes the request's write data into the word. Its response returns the word's previous contents.
- R7: Opcode 2'b10 (test-and-set) returns the previous contents and writes SET_VAL into the word.
- R8: Accesses take effect in acceptance order. A request accepted in the cycle right after a store or test-and-set to the same word sees that write's result, so no access can fall between the read and the write of a test-and-set.
- R9: While a requester holds a lock, a test-and-set on that word by any other requester returns SET_VAL with `rsp_ok` = 0. A store of CLR_VAL frees the word, and the next test-and-set on it succeeds.
- R10: Opcode 2'b11 behaves exactly as a load.
- R11: `rsp_ok` is 1 only for a test-and-set whose returned old value equals CLR_VAL. For every load and store it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_REQ | Request present, bit i for requester i |
| req_ready | output | N_REQ | Request accepted this cycle, bit i for requester i |
| req_op | input | 2*N_REQ | Opcode of requester i at bits [2i+1:2i] |
| req_addr | input | ADDR_W*N_REQ | Word address of requester i at bits [ADDR_W*i +: ADDR_W] |
| req_wdata | input | DATA_W*N_REQ | Store data of requester i at bits [DATA_W*i +: DATA_W] |
| rsp_valid | output | N_REQ | Response present on lane i |
| rsp_rdata | output | DATA_W*N_REQ | Old word contents on lane i at bits [DATA_W*i +: DATA_W] |
| rsp_ok | output | N_REQ | Lane i test-and-set acquired the lock |

## Verification
Each response is compared against a word model kept by the testbench. Any stale or lost write therefore shows up at the ports two cycles after the next access to that word, as wrong old data. If that access is a test-and-set, a second requester sees `rsp_ok` while an earlier owner still holds the lock. A fault in the round-robin pointer shows up as a requester waiting more than N_REQ-1 grants. A fault in the start-up sweep shows up as a wrong hold-off length or a lock word that does not read as CLR_VAL.

// File: rtl/tas_lock_pkg.sv
package tas_lock_pkg;

  // Request opcodes; 2'b11 is serviced as a load
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_TAS   = 2'b10,
    OP_PEEK  = 2'b11
  } lock_op_e;

endpackage

// File: rtl/tas_rr_arb.sv
module tas_rr_arb #(
  parameter int N_REQ = 4,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] gnt,
  output logic             gnt_any,
  output logic [IDX_W-1:0] gnt_idx
);

  // Search starts at the requester after the last winner
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] cand;

  always_comb begin
    gnt     = '0;
    gnt_any = 1'b0;
    gnt_idx = '0;
    cand    = '0;
    for (int k = 0; k < N_REQ; k++) begin
      cand = IDX_W'((int'(ptr_q) + k) % N_REQ);
      if (en && !gnt_any && req[cand]) begin
        gnt[cand] = 1'b1;
        gnt_any   = 1'b1;
        gnt_idx   = cand;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (gnt_any) begin
      ptr_q <= (gnt_idx == IDX_W'(N_REQ - 1)) ? '0 : gnt_idx + 1'b1;
    end
  end

endmodule

// File: rtl/tas_lock_ram.sv
module tas_lock_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  // Simple dual-port, read-first, registered read
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/tas_lock_mem.sv
module tas_lock_mem
  import tas_lock_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] SET_VAL = DATA_W'(1),
  parameter logic [DATA_W-1:0] CLR_VAL = DATA_W'(0)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_REQ-1:0]         req_valid,
  output logic [N_REQ-1:0]         req_ready,
  input  logic [N_REQ*2-1:0]       req_op,
  input  logic [N_REQ*ADDR_W-1:0]  req_addr,
  input  logic [N_REQ*DATA_W-1:0]  req_wdata,
  output logic [N_REQ-1:0]         rsp_valid,
  output logic [N_REQ*DATA_W-1:0]  rsp_rdata,
  output logic [N_REQ-1:0]         rsp_ok
);

  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;
  localparam int DEPTH = 1 << ADDR_W;

  // Start-up sweep writing the clear constant into every word
  logic              init_busy;
  logic [ADDR_W-1:0] init_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_busy <= 1'b1;
      init_addr <= '0;
    end else if (init_busy) begin
      init_addr <= init_addr + 1'b1;
      if (init_addr == ADDR_W'(DEPTH - 1)) begin
        init_busy <= 1'b0;
      end
    end
  end

  // One grant per cycle
  logic             gnt_any;
  logic [IDX_W-1:0] gnt_idx;

  tas_rr_arb #(.N_REQ(N_REQ)) i_arb (
    .clk    (clk),
    .rst    (rst),
    .en     (!init_busy),
    .req    (req_valid),
    .gnt    (req_ready),
    .gnt_any(gnt_any),
    .gnt_idx(gnt_idx)
  );

  // Fields of the granted request
  lock_op_e          sel_op;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata;

  always_comb begin
    sel_op    = OP_LOAD;
    sel_addr  = '0;
    sel_wdata = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (req_ready[i]) begin
        sel_op    = lock_op_e'(req_op[i*2 +: 2]);
        sel_addr  = req_addr[i*ADDR_W +: ADDR_W];
        sel_wdata = req_wdata[i*DATA_W +: DATA_W];
      end
    end
  end

  // Execute stage: old value available, write issued
  logic              s1_vld;
  logic [IDX_W-1:0]  s1_id;
  lock_op_e          s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] s1_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld   <= 1'b0;
      s1_id    <= '0;
      s1_op    <= OP_LOAD;
      s1_addr  <= '0;
      s1_wdata <= '0;
    end else begin
      s1_vld   <= gnt_any;
      s1_id    <= gnt_idx;
      s1_op    <= sel_op;
      s1_addr  <= sel_addr;
      s1_wdata <= sel_wdata;
    end
  end

  logic              s1_writes;
  logic [DATA_W-1:0] s1_wval;

  assign s1_writes = s1_vld && ((s1_op == OP_STORE) || (s1_op == OP_TAS));
  assign s1_wval   = (s1_op == OP_TAS) ? SET_VAL : s1_wdata;

  // Storage
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_rdata;

  assign ram_we    = init_busy || s1_writes;
  assign ram_waddr = init_busy ? init_addr : s1_addr;
  assign ram_wdata = init_busy ? CLR_VAL : s1_wval;

  tas_lock_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .raddr(sel_addr),
    .rdata(ram_rdata)
  );

  // Same-edge write/read of one word: the read-first RAM returns the
  // pre-write value, so the written value is captured and used instead
  logic              byp_hit_q;
  logic [DATA_W-1:0] byp_val_q;
  logic [DATA_W-1:0] old_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_hit_q <= 1'b0;
      byp_val_q <= '0;
    end else begin
      byp_hit_q <= s1_writes && (s1_addr == sel_addr);
      byp_val_q <= s1_wval;
    end
  end

  assign old_val = byp_hit_q ? byp_val_q : ram_rdata;

  // Registered response lanes
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= '0;
      rsp_rdata <= '0;
      rsp_ok    <= '0;
    end else begin
      for (int i = 0; i < N_REQ; i++) begin
        rsp_valid[i] <= s1_vld && (s1_id == IDX_W'(i));
        if (s1_vld && (s1_id == IDX_W'(i))) begin
          rsp_rdata[i*DATA_W +: DATA_W] <= old_val;
          rsp_ok[i] <= (s1_op == OP_TAS) && (old_val == CLR_VAL);
        end
      end
    end
  end

endmodule

// File: rtl/tas_lock_mem_chk.sv
module tas_lock_mem_chk #(
  parameter int N_REQ  = 4,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CLR_VAL = DATA_W'(0)
) (
  input logic                    clk,
  input logic                    rst,
  input logic [N_REQ-1:0]        req_valid,
  input logic [N_REQ-1:0]        req_ready,
  input logic [N_REQ-1:0]        rsp_valid,
  input logic [N_REQ-1:0]        rsp_ok,
  input logic [N_REQ*DATA_W-1:0] rsp_rdata
);

  localparam int WAIT_W = $clog2(N_REQ + 1) + 1;

  // Grants to others seen while a requester waits
  logic [WAIT_W-1:0] wait_q [N_REQ];

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_REQ; i++) begin
      if (rst || !req_valid[i] || req_ready[i]) begin
        wait_q[i] <= '0;
      end else if (|req_ready) begin
        wait_q[i] <= wait_q[i] + 1'b1;
      end
    end
  end

  // R2
  single_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ready));

  // R2
  grant_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ready & ~req_valid) == '0);

  // R4
  rsp_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == $past(req_valid & req_ready, 2));

  // R4
  rsp_single_lane_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rsp_valid));

  for (genvar g = 0; g < N_REQ; g++) begin : g_lane
    // R3
    fair_wait_chk: assert property (@(posedge clk) disable iff (rst)
      wait_q[g] < WAIT_W'(N_REQ));

    // R11
    ok_old_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid[g] && rsp_ok[g]) |-> (rsp_rdata[g*DATA_W +: DATA_W] == CLR_VAL));
  end

endmodule

bind tas_lock_mem tas_lock_mem_chk #(
  .N_REQ  (N_REQ),
  .DATA_W (DATA_W),
  .CLR_VAL(CLR_VAL)
) i_tas_lock_mem_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_ok   (rsp_ok),
  .rsp_rdata(rsp_rdata)
);

// File: tb/test_tas_lock_mem.sv
`timescale 1ns/1ps
module test_tas_lock_mem;

  localparam int N     = 4;
  localparam int AW    = 3;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [DW-1:0] SETV = 8'h5A;
  localparam logic [DW-1:0] CLRV = 8'hC3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst;
  logic [N-1:0]     req_valid;
  logic [N-1:0]     req_ready;
  logic [N*2-1:0]   req_op;
  logic [N*AW-1:0]  req_addr;
  logic [N*DW-1:0]  req_wdata;
  logic [N-1:0]     rsp_valid;
  logic [N*DW-1:0]  rsp_rdata;
  logic [N-1:0]     rsp_ok;

  tas_lock_mem #(
    .N_REQ(N), .ADDR_W(AW), .DATA_W(DW), .SET_VAL(SETV), .CLR_VAL(CLRV)
  ) i_tas_lock_mem (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bench model
  logic [DW-1:0] mem_m [DEPTH];
  int            holder [DEPTH];
  bit            want [N];
  logic [1:0]    w_op [N];
  logic [AW-1:0] w_addr [N];
  logic [DW-1:0] w_data [N];
  bit            acc_last [N];
  bit            outst [N];
  int            wt [N];
  bit            p0_v [N], p1_v [N], p0_ok [N], p1_ok [N], p0_tas [N], p1_tas [N];
  logic [DW-1:0] p0_rd [N], p1_rd [N];
  logic [AW-1:0] p0_a [N], p1_a [N];
  logic [DW-1:0] last_rd [N];
  bit            last_ok [N];

  task automatic issue(input int i, input logic [1:0] op, input int a, input logic [DW-1:0] d);
    want[i]   = 1'b1;
    w_op[i]   = op;
    w_addr[i] = AW'(a);
    w_data[i] = d;
  endtask

  task automatic step();
    @(negedge clk);
    // responses due this cycle
    for (int i = 0; i < N; i++) begin
      chk(rsp_valid[i] == p1_v[i], "R4 response lane timing", int'(rsp_valid[i]), int'(p1_v[i]));
      if (p1_v[i] && rsp_valid[i]) begin
        chk(rsp_rdata[i*DW +: DW] == p1_rd[i], "R5 R6 R7 R8 R10 old data",
            int'(rsp_rdata[i*DW +: DW]), int'(p1_rd[i]));
        chk(rsp_ok[i] == p1_ok[i], "R7 R11 success flag", int'(rsp_ok[i]), int'(p1_ok[i]));
        last_rd[i] = rsp_rdata[i*DW +: DW];
        last_ok[i] = rsp_ok[i];
        outst[i]   = 1'b0;
        if (p1_tas[i] && rsp_ok[i]) begin
          chk(holder[p1_a[i]] < 0, "R9 mutual exclusion", holder[p1_a[i]], -1);
          holder[p1_a[i]] = i;
        end
      end
      p1_v[i] = p0_v[i]; p1_rd[i] = p0_rd[i]; p1_ok[i] = p0_ok[i];
      p1_tas[i] = p0_tas[i]; p1_a[i] = p0_a[i];
    end
    // drive
    for (int i = 0; i < N; i++) begin
      if (acc_last[i]) begin
        req_valid[i] = 1'b0;
        acc_last[i]  = 1'b0;
      end
      if (want[i] && !req_valid[i]) begin
        req_op[i*2 +: 2]     = w_op[i];
        req_addr[i*AW +: AW] = w_addr[i];
        req_wdata[i*DW +: DW] = w_data[i];
        req_valid[i] = 1'b1;
      end
    end
    #1;
    chk(($countones(req_ready) <= 1) && ((req_ready & ~req_valid) == '0),
        "R2 single grant", int'(req_ready), int'(req_valid));
    for (int i = 0; i < N; i++) begin
      p0_v[i] = 1'b0;
      if (req_valid[i] && req_ready[i]) begin
        logic [1:0]    op;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        op = req_op[i*2 +: 2];
        a  = req_addr[i*AW +: AW];
        d  = req_wdata[i*DW +: DW];
        p0_v[i]   = 1'b1;
        p0_a[i]   = a;
        p0_rd[i]  = mem_m[a];
        p0_tas[i] = (op == 2'b10);
        p0_ok[i]  = (op == 2'b10) && (mem_m[a] == CLRV);
        if (op == 2'b01) mem_m[a] = d;
        if (op == 2'b10) mem_m[a] = SETV;
        if (op == 2'b01 && d == CLRV && holder[a] == i) holder[a] = -1;
        chk(wt[i] <= N - 1, "R3 round-robin wait bound", wt[i], N - 1);
        wt[i]       = 0;
        want[i]     = 1'b0;
        acc_last[i] = 1'b1;
        outst[i]    = 1'b1;
      end else if (req_valid[i] && (|req_ready)) begin
        wt[i]++;
      end
    end
  endtask

  task automatic drain();
    bit busy;
    busy = 1'b1;
    while (busy) begin
      step();
      busy = 1'b0;
      for (int i = 0; i < N; i++) if (want[i] || outst[i]) busy = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int seed_dummy;
    seed_dummy = $urandom(32'd4242);
    rst = 1'b1;
    req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0;
    for (int a = 0; a < DEPTH; a++) begin
      mem_m[a] = CLRV;
      holder[a] = -1;
    end
    for (int i = 0; i < N; i++) begin
      want[i] = 0; acc_last[i] = 0; outst[i] = 0; wt[i] = 0;
      p0_v[i] = 0; p1_v[i] = 0; p0_ok[i] = 0; p1_ok[i] = 0; p0_tas[i] = 0; p1_tas[i] = 0;
      p0_rd[i] = '0; p1_rd[i] = '0; p0_a[i] = '0; p1_a[i] = '0; last_rd[i] = '0; last_ok[i] = 0;
    end
    repeat (5) @(posedge clk);
    #1;
    chk(rsp_valid == '0 && req_ready == '0, "R1 reset outputs idle", int'(rsp_valid), 0);
    @(negedge clk);
    rst = 1'b0;

    // R1: hold-off length and cleared words
    issue(0, 2'b00, DEPTH - 1, 0);
    n = 0;
    while (want[0]) begin step(); n++; end
    chk(n == DEPTH, "R1 start-up hold-off cycles", n, DEPTH);
    drain();
    chk(last_rd[0] == CLRV, "R1 word cleared after reset", int'(last_rd[0]), int'(CLRV));

    // R7 R9: acquire, contend, release, reacquire
    issue(0, 2'b10, 0, 0); drain();
    chk(last_ok[0] && last_rd[0] == CLRV, "R7 first test-and-set acquires", int'(last_rd[0]), int'(CLRV));
    issue(1, 2'b10, 0, 0); drain();
    chk(!last_ok[1] && last_rd[1] == SETV, "R9 held lock refuses other", int'(last_rd[1]), int'(SETV));
    issue(0, 2'b01, 0, CLRV); drain();
    chk(!last_ok[0], "R11 store reports no success", int'(last_ok[0]), 0);
    issue(1, 2'b10, 0, 0); drain();
    chk(last_ok[1], "R9 freed lock reacquired", int'(last_ok[1]), 1);
    issue(1, 2'b01, 0, CLRV); drain();

    // R8: same-cycle contention on one word, exactly one winner
    issue(2, 2'b10, 1, 0);
    issue(3, 2'b10, 1, 0);
    drain();
    chk(last_ok[2] ^ last_ok[3], "R8 one winner of back-to-back test-and-set",
        int'(last_ok[2]) + int'(last_ok[3]), 1);
    issue(last_ok[2] ? 2 : 3, 2'b01, 1, CLRV); drain();

    // R6 R5 R10: store, peek, load
    issue(0, 2'b01, 2, 8'h11); drain();
    chk(last_rd[0] == CLRV, "R6 store returns previous contents", int'(last_rd[0]), int'(CLRV));
    issue(1, 2'b01, 2, 8'h22); drain();
    chk(last_rd[1] == 8'h11, "R6 store result visible", int'(last_rd[1]), 8'h11);
    issue(2, 2'b11, 2, 0); drain();
    chk(last_rd[2] == 8'h22, "R10 opcode 3 reads like load", int'(last_rd[2]), 8'h22);
    issue(3, 2'b00, 2, 0); drain();
    chk(last_rd[3] == 8'h22 && !last_ok[3], "R5 load leaves word unchanged", int'(last_rd[3]), 8'h22);

    // R3: four simultaneous requests served in four cycles
    for (int i = 0; i < N; i++) issue(i, 2'b00, i, 0);
    n = 0;
    while (want[0] || want[1] || want[2] || want[3]) begin step(); n++; end
    chk(n == N, "R3 all requesters served in turn", n, N);
    drain();

    // Random contention on lock words 0 and 1, data in 2..7
    for (int s = 0; s < 4000; s++) begin
      for (int i = 0; i < N; i++) begin
        if (!want[i] && !outst[i]) begin
          int r;
          int held;
          r = int'($urandom_range(0, 9));
          held = -1;
          for (int a = 0; a < 2; a++) if (holder[a] == i) held = a;
          if (held >= 0) begin
            if (r < 3) issue(i, 2'b01, held, CLRV);
            else if (r < 5) issue(i, 2'b00, 2 + int'($urandom_range(0, 5)), 0);
          end else begin
            if (r < 5) issue(i, 2'b10, int'($urandom_range(0, 1)), 0);
            else if (r < 7) issue(i, 2'b01, 2 + int'($urandom_range(0, 5)), DW'($urandom));
            else if (r < 9) issue(i, (r == 7) ? 2'b00 : 2'b11, int'($urandom_range(0, DEPTH - 1)), 0);
          end
        end
      end
      step();
    end
    drain();

    // Release every lock still held, then both must be free
    for (int a = 0; a < 2; a++) begin
      if (holder[a] >= 0) begin
        issue(holder[a], 2'b01, a, CLRV);
        drain();
      end
    end
    issue(0, 2'b10, 0, 0); drain();
    chk(last_ok[0], "R9 lock word 0 free after release", int'(last_ok[0]), 1);
    issue(0, 2'b10, 1, 0); drain();
    chk(last_ok[0], "R9 lock word 1 free after release", int'(last_ok[0]), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule